// File: doc/BRIEF.md
# Power-of-Two Period Countdown Timer Bank

This block holds a bank of one-byte countdown timers. The timers are split into groups, and each group steps at a power-of-two multiple of a shared base tick: every tick, every second tick, every fourth tick, and so on up to a parameterized number of groups. A single free-running modulo counter advances on each base tick. Its low bits decide which groups step on that tick. All timers in a selected group step together in the same clock cycle. A timer counts down to zero, stops there, and reports expiry while its value is zero.

Software starts a measurement by writing a nonzero count to a timer through the load port. It then polls the per-timer expiry flags or reads the remaining count through the read port. The group that a timer belongs to sets its resolution. With a one-byte count and power-of-two periods, any interval can be covered with roughly 1/128 relative error. For example, a tick period of 8192 ms and a load value of 220 give about half an hour.

The load port is a valid/ready stream. `load_ready` is held high at all times, so the port never back-pressures. A write is accepted on any clock edge where `load_valid` is high. The read port and the expiry flags are plain combinational outputs.

Top module: `dtb_top`

## Requirements
- R1: After reset every timer holds 0, every bit of `expired` is 1, and the modulo counter is 0.
- R2: When `load_valid` is high at a clock edge and `load_idx` is below NUM_TIMERS, timer `load_idx` holds `load_data` after that edge. Timer index i belongs to group i / TIMERS_PER_GROUP.
- R3: Group 0 timers decrement by one on every clock edge where `tick` is high.
- R4: A group d timer (d ≥ 1, period 2^d ticks) decrements on a tick only when the low d bits of the modulo counter are all zero before that tick. The first tick after reset therefore steps every group.
- R5: A timer whose value is 0 stays at 0 when stepped and never wraps. `expired[i]` is 1 exactly when timer i holds 0.
- R6: When a load and a step hit the same timer at the same edge, the loaded value wins and no decrement is applied.
- R7: On edges where `tick` is low and no load is accepted, no timer changes.
- R8: A load with `load_idx` at or above NUM_TIMERS changes no timer.
- R9: The modulo counter advances by one on every tick and wraps modulo 2^(NUM_DECADES-1). Group d therefore steps exactly once in every 2^d ticks.
- R10: `rd_data` shows the current value of timer `rd_idx` in the same cycle. It shows 0 for an index outside the bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Base tick strobe, one cycle per tick |
| load_valid | input | 1 | Load request valid |
| load_ready | output | 1 | Load request accepted (always 1) |
| load_idx | input | IDX_W | Index of the timer to load |
| load_data | input | CNT_W | Count to load |
| rd_idx | input | IDX_W | Index of the timer to read |
| rd_data | output | CNT_W | Current count of timer `rd_idx` |
| expired | output | NUM_TIMERS | Per-timer flag, high while the count is zero |

## Verification
The hardest case to reach is a load that collides with a step of a slow group. A load on a period-4 timer only collides with a real decrement on the one tick in four where the modulo counter's low bits are zero. The bench keeps its own model of the modulo counter, so it can place load-plus-tick cycles on chosen phases of that counter. It also lets bursts of ticks run long enough for every group to pass through the saturating zero state.

// File: rtl/dtb_pkg.sv
package dtb_pkg;
  // width needed to index n items, never below one bit
  function automatic int unsigned idx_width(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  // modulo counter width for a number of period groups
  function automatic int unsigned mod_width(input int unsigned groups);
    return (groups <= 1) ? 1 : groups - 1;
  endfunction
endpackage

// File: rtl/dtb_modulo.sv
module dtb_modulo
  import dtb_pkg::*;
#(
  parameter int unsigned NUM_DECADES = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  output logic [NUM_DECADES-1:0] step
);
  localparam int unsigned MW = mod_width(NUM_DECADES);

  logic [MW-1:0] mod_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mod_q <= '0;
    else if (tick) mod_q <= mod_q + MW'(1);
  end

  assign step[0] = tick;

  for (genvar d = 1; d < NUM_DECADES; d++) begin : g_gate
    assign step[d] = tick && (mod_q[d-1:0] == '0);

    // R4
    nested_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step[d] |-> step[d-1]);
  end

  // R9
  mod_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> mod_q == $past(mod_q) + MW'(1));

  // R9
  mod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(mod_q));
endmodule

// File: rtl/dtb_cell.sv
module dtb_cell #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step_en,
  output logic [CNT_W-1:0] cnt,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (load_en)                  cnt_q <= load_val;
    else if (step_en && cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign cnt  = cnt_q;
  assign zero = (cnt_q == '0);

  // R6
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> cnt_q == $past(load_val));

  // R5
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && cnt_q == '0) |=> cnt_q == '0);

  // R3
  dec_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !load_en) |=> $stable(cnt_q));
endmodule

// File: rtl/dtb_readmux.sv
module dtb_readmux #(
  parameter int unsigned N     = 12,
  parameter int unsigned CNT_W = 8,
  parameter int unsigned IW    = 4
) (
  input  logic [N*CNT_W-1:0] vals,
  input  logic [IW-1:0]      sel,
  output logic [CNT_W-1:0]   out
);
  always_comb begin
    out = '0;
    for (int i = 0; i < N; i++) begin
      if (sel == IW'(i)) out = vals[i*CNT_W +: CNT_W];
    end
  end
endmodule

// File: rtl/dtb_top.sv
module dtb_top
  import dtb_pkg::*;
#(
  parameter int unsigned NUM_DECADES      = 3,
  parameter int unsigned TIMERS_PER_GROUP = 4,
  parameter int unsigned CNT_W            = 8,
  parameter int unsigned NUM_TIMERS       = NUM_DECADES * TIMERS_PER_GROUP,
  parameter int unsigned IDX_W            = idx_width(NUM_TIMERS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  load_valid,
  output logic                  load_ready,
  input  logic [IDX_W-1:0]      load_idx,
  input  logic [CNT_W-1:0]      load_data,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [CNT_W-1:0]      rd_data,
  output logic [NUM_TIMERS-1:0] expired
);
  logic [NUM_DECADES-1:0]      step;
  logic [NUM_TIMERS*CNT_W-1:0] cnt_flat;

  assign load_ready = 1'b1;

  dtb_modulo #(.NUM_DECADES(NUM_DECADES)) mod_i (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick),
    .step (step)
  );

  for (genvar g = 0; g < NUM_DECADES; g++) begin : g_grp
    for (genvar t = 0; t < TIMERS_PER_GROUP; t++) begin : g_tmr
      localparam int unsigned K = g * TIMERS_PER_GROUP + t;
      logic ld;
      assign ld = load_valid && (load_idx == IDX_W'(K));

      dtb_cell #(.CNT_W(CNT_W)) cell_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (ld),
        .load_val(load_data),
        .step_en (step[g]),
        .cnt     (cnt_flat[K*CNT_W +: CNT_W]),
        .zero    (expired[K])
      );
    end
  end

  dtb_readmux #(.N(NUM_TIMERS), .CNT_W(CNT_W), .IW(IDX_W)) rd_i (
    .vals(cnt_flat),
    .sel (rd_idx),
    .out (rd_data)
  );

  // R8
  oob_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && int'(load_idx) >= int'(NUM_TIMERS) && !tick) |=> $stable(cnt_flat));

  // R5
  flag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_idx) < int'(NUM_TIMERS)) |-> ((rd_data == '0) == expired[rd_idx]));
endmodule

// File: tb/dtb_top_tb_top.sv
module dtb_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 3;
  localparam int G  = 4;
  localparam int N  = ND * G;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic load_valid = 1'b0;
  logic load_ready;
  logic [IW-1:0] load_idx = '0;
  logic [7:0] load_data = '0;
  logic [IW-1:0] rd_idx = '0;
  logic [7:0] rd_data;
  logic [N-1:0] expired;

  int checks = 0;
  int errors = 0;
  int model [N];
  int mcnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dtb_top dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .load_valid(load_valid), .load_ready(load_ready),
    .load_idx(load_idx), .load_data(load_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .expired(expired)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // compare every timer and flag against the model
  task automatic chk_all(input string req);
    for (int i = 0; i < N; i++) begin
      rd_idx = IW'(i);
      #1;
      chk(req, int'(rd_data), model[i]);
      chk(req, int'(expired[i]), (model[i] == 0) ? 1 : 0);
    end
  endtask

  // one clock cycle with given stimulus, model updated
  task automatic cycle(input bit tk, input bit lv, input int idx, input int data);
    @(negedge clk);
    tick = tk; load_valid = lv; load_idx = IW'(idx); load_data = 8'(data);
    @(negedge clk);
    tick = 1'b0; load_valid = 1'b0;
    for (int i = 0; i < N; i++) begin
      int d;
      bit st;
      d = i / G;
      st = tk && ((d == 0) || ((mcnt & ((1 << d) - 1)) == 0));
      if (lv && idx == i) model[i] = data;
      else if (st && model[i] != 0) model[i] = model[i] - 1;
    end
    if (tk) mcnt++;
  endtask

  task automatic t_reset();
    chk("R1 expired vector", int'(expired), (1 << N) - 1);
    chk("R8 load_ready high", int'(load_ready), 1);
    chk_all("R1 reset values");
  endtask

  task automatic t_load();
    for (int i = 0; i < N; i++) cycle(1'b0, 1'b1, i, 20 + 3 * i);
    chk_all("R2 R10 load and read");
    rd_idx = IW'(N + 1);
    #1;
    chk("R10 out of range read", int'(rd_data), 0);
  endtask

  task automatic t_ticks();
    for (int k = 0; k < 9; k++) begin
      cycle(1'b1, 1'b0, 0, 0);
      chk_all("R3 R4 R9 group stepping");
    end
  endtask

  task automatic t_saturate();
    cycle(1'b0, 1'b1, 1, 2);
    cycle(1'b0, 1'b1, 2 * G, 1);
    for (int k = 0; k < 6; k++) cycle(1'b1, 1'b0, 0, 0);
    rd_idx = IW'(1);
    #1;
    chk("R5 group0 saturates", int'(rd_data), 0);
    chk("R5 expired raised", int'(expired[1]), 1);
    rd_idx = IW'(2 * G);
    #1;
    chk("R5 group2 saturates", int'(rd_data), 0);
    chk_all("R5 model after saturation");
  endtask

  task automatic t_priority();
    // align so that the slow group steps on the next tick
    while ((mcnt & 3) != 0) cycle(1'b1, 1'b0, 0, 0);
    cycle(1'b1, 1'b1, 2 * G + 1, 77);
    rd_idx = IW'(2 * G + 1);
    #1;
    chk("R6 load beats step slow group", int'(rd_data), 77);
    cycle(1'b1, 1'b1, 0, 40);
    rd_idx = '0;
    #1;
    chk("R6 load beats step group0", int'(rd_data), 40);
    chk_all("R6 others stepped");
  endtask

  task automatic t_idle();
    for (int k = 0; k < 5; k++) cycle(1'b0, 1'b0, 0, 0);
    chk_all("R7 idle hold");
  endtask

  task automatic t_oob();
    cycle(1'b0, 1'b1, N, 9);
    cycle(1'b0, 1'b1, 15, 9);
    chk_all("R8 out-of-range load ignored");
  endtask

  task automatic t_period();
    // load one timer per group with 200, run 16 ticks
    for (int g = 0; g < ND; g++) cycle(1'b0, 1'b1, g * G + 3, 200);
    for (int k = 0; k < 16; k++) cycle(1'b1, 1'b0, 0, 0);
    rd_idx = IW'(3);       #1; chk("R9 period-1 drop", int'(rd_data), 184);
    rd_idx = IW'(G + 3);   #1; chk("R9 period-2 drop", int'(rd_data), 192);
    rd_idx = IW'(2*G + 3); #1; chk("R9 period-4 drop", int'(rd_data), 196);
    chk_all("R9 model");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_load();
    t_ticks();
    t_saturate();
    t_priority();
    t_idle();
    t_oob();
    t_period();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule